// File: doc/BRIEF.md
# Chip-Select Serial Readout Controller

This block is the device-side control logic of a three-wire serial converter port. A host drives an active-low select and an I/O clock. The block runs on a faster system clock and treats both host signals as asynchronous inputs. It synchronises them and accepts a select change only once the new level has been held long enough. It then counts I/O clock falling edges and shifts the previous 10-bit result out MSB first on a data line that is released whenever the part is deselected.

The same edge count controls the analog side. A sample window opens on the third falling edge and closes on the tenth. The tenth edge also hands control to the converter through a one-cycle start pulse. The block accepts a 10-clock frame or a frame of up to 16 clocks. It works both with the select toggled between frames and with the select held low, where it reloads the fresh result by itself. A late I/O clock after the tenth edge is reported as loss of synchronisation, and only a select change clears it.

Top module: `serial_readout_ctrl`

## Requirements
- R1: While the qualified select is inactive, `dout_oe_o` is low, and I/O clock edges produce no sample window and no conversion start.
- R2: A level change on `cs_ni` takes effect only after it has been held for `QUAL_CYC` system cycles. `dout_oe_o` follows a held falling change exactly `QUAL_CYC`+3 cycles after the pin changes. A low pulse of `QUAL_CYC`-2 cycles leaves the block deselected.
- R3: On activation, `dout_o` shows bit 9 of `result_i`. Each I/O clock falling edge moves to the next lower bit, so bit 0 shows after the ninth edge. Outputs update 3 system cycles after the pin falls.
- R4: The tenth falling edge forces `dout_o` low, and any further edges in the frame keep it low.
- R5: `sample_en_o` rises on the third falling edge and falls on the tenth.
- R6: `conv_start_o` is a single-cycle pulse, issued once per frame on the tenth falling edge.
- R7: With the select held low and no I/O clock rise after the tenth edge, the block reloads `result_i` once `conv_done_i` has been seen. It then shows the new bit 9 and restarts the edge count.
- R8: With the select held low and extra clocks after the tenth edge, the reload waits for both the sixteenth falling edge and `conv_done_i`, whichever comes last.
- R9: After the tenth edge, the first I/O clock rise must come within `SYNC_TO_CYC` cycles while the conversion is pending. If it comes later, `sync_lost_o` is set and `dout_o` is held low, and all edges and reloads are ignored until the next qualified select change clears the flag.
- R10: A qualified select activation during a frame aborts it. The output restarts at bit 9, no conversion is started and the sample window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host select, active low, asynchronous |
| ioclk_i | input | 1 | Host I/O clock, asynchronous |
| result_i | input | DATA_W | Previous conversion result |
| conv_done_i | input | 1 | Converter finished, single-cycle pulse |
| dout_o | output | 1 | Serial data |
| dout_oe_o | output | 1 | Data output enable |
| sample_en_o | output | 1 | Analog sample window |
| conv_start_o | output | 1 | Conversion launch pulse |
| sync_lost_o | output | 1 | Late clock after the tenth edge |

## Verification
Each pin-level event has a fixed delay before it shows at the outputs, because of the two synchroniser flops and one state register:
- An I/O clock fall changes `dout_o`, `sample_en_o` and `conv_start_o` three system cycles later.
- A held select change moves `dout_oe_o` `QUAL_CYC`+3 cycles later.
- A `conv_done_i` pulse leads to a reload two cycles later.

The bench changes inputs on the falling system edge and holds every I/O clock half-period for four system cycles, so every check lands after the latest of these delays. Only the select-qualification test is sampled on both sides of the exact `QUAL_CYC`+3 boundary. Conversion-start pulses are counted on every sampled cycle, so each frame can be checked for exactly one start.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CONV,
    ST_LOST
  } srd_state_e;
endpackage

// File: rtl/srd_sync.sv
module srd_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] stg;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg <= {2{RST_VAL[g]}};
      else         stg <= {stg[0], d_i[g]};
    end
    assign q_o[g] = stg[1];
  end
endmodule

// File: rtl/srd_edge.sv
module srd_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= RST_VAL;
    else         prev <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev;
  assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/srd_cs_qual.sv
module srd_cs_qual #(
  parameter int unsigned HOLD_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_n_i,
  output logic act_o,
  output logic on_o,
  output logic off_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic          lvl;
  logic [CW-1:0] cnt;

  // level must differ for HOLD_CYC consecutive cycles before it is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl   <= 1'b1;
      cnt   <= '0;
      on_o  <= 1'b0;
      off_o <= 1'b0;
    end else begin
      on_o  <= 1'b0;
      off_o <= 1'b0;
      if (sel_n_i != lvl) begin
        if (cnt == CW'(HOLD_CYC - 1)) begin
          lvl   <= sel_n_i;
          cnt   <= '0;
          on_o  <= ~sel_n_i;
          off_o <= sel_n_i;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign act_o = ~lvl;
endmodule

// File: rtl/serial_readout_ctrl.sv
module serial_readout_ctrl #(
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned QUAL_CYC    = 6,
  parameter int unsigned SYNC_TO_CYC = 40,
  parameter int unsigned SAMPLE_EDGE = 3,
  parameter int unsigned CONV_EDGE   = 10,
  parameter int unsigned LAST_EDGE   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ioclk_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              conv_done_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              sample_en_o,
  output logic              conv_start_o,
  output logic              sync_lost_o
);
  import srd_pkg::*;

  localparam int unsigned CNT_W = $clog2(LAST_EDGE + 1);
  localparam int unsigned TMR_W = $clog2(SYNC_TO_CYC + 1);

  logic [1:0] sync_q;
  logic       cs_act, cs_on, cs_off;
  logic       io_rise, io_fall;

  srd_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ioclk_i, cs_ni}),
    .q_o   (sync_q)
  );

  srd_cs_qual #(.HOLD_CYC(QUAL_CYC)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_n_i(sync_q[0]),
    .act_o  (cs_act),
    .on_o   (cs_on),
    .off_o  (cs_off)
  );

  srd_edge #(.RST_VAL(1'b0)) u_ioedge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_q[1]),
    .rise_o(io_rise),
    .fall_o(io_fall)
  );

  srd_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [TMR_W-1:0]  tmr;
  logic [DATA_W-1:0] shreg;
  logic              busy, tail, sample_q, start_q, lost_q;
  logic              reload;

  // continuous select: reload once converter is idle and the frame is done
  assign reload = !busy && (!tail || cnt == CNT_W'(LAST_EDGE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      tmr      <= '0;
      shreg    <= '0;
      busy     <= 1'b0;
      tail     <= 1'b0;
      sample_q <= 1'b0;
      start_q  <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (conv_done_i) busy <= 1'b0;
      if (cs_off) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        shreg    <= '0;
        tail     <= 1'b0;
        sample_q <= 1'b0;
        lost_q   <= 1'b0;
      end else if (cs_on) begin
        state    <= ST_SHIFT;
        cnt      <= '0;
        shreg    <= result_i;
        tail     <= 1'b0;
        sample_q <= 1'b0;
        lost_q   <= 1'b0;
      end else begin
        unique case (state)
          ST_SHIFT: begin
            if (io_fall) begin
              cnt <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(CONV_EDGE - 1)) begin
                shreg    <= '0;
                sample_q <= 1'b0;
                start_q  <= 1'b1;
                busy     <= 1'b1;
                tmr      <= '0;
                state    <= ST_CONV;
              end else begin
                shreg <= {shreg[DATA_W-2:0], 1'b0};
                if (cnt == CNT_W'(SAMPLE_EDGE - 1)) sample_q <= 1'b1;
              end
            end
          end
          ST_CONV: begin
            if (reload) begin
              state <= ST_SHIFT;
              cnt   <= '0;
              shreg <= result_i;
              tail  <= 1'b0;
            end else begin
              if (tmr != TMR_W'(SYNC_TO_CYC)) tmr <= tmr + TMR_W'(1);
              if (io_rise && !tail) begin
                if (tmr == TMR_W'(SYNC_TO_CYC)) begin
                  state  <= ST_LOST;
                  lost_q <= 1'b1;
                end else begin
                  tail <= 1'b1;
                end
              end
              if (io_fall && cnt != CNT_W'(LAST_EDGE)) cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_o       = shreg[DATA_W-1];
  assign dout_oe_o    = (state != ST_IDLE);
  assign sample_en_o  = sample_q;
  assign conv_start_o = start_q;
  assign sync_lost_o  = lost_q;
endmodule

// File: rtl/srd_checker.sv
module srd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act_i,
  input logic cs_on_i,
  input logic cs_off_i,
  input logic dout_i,
  input logic dout_oe_i,
  input logic sample_en_i,
  input logic conv_start_i,
  input logic sync_lost_i
);
  a_r1_no_drive_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act_i && !cs_off_i) |-> !dout_oe_i);

  a_r2_single_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_on_i && cs_off_i));

  a_r2_on_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_on_i |-> cs_act_i);

  a_r2_oe_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_on_i |=> dout_oe_i);

  a_r4_pad_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |-> !dout_i);

  a_r5_window_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |-> !sample_en_i);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |=> !conv_start_i);

  a_r9_lost_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_lost_i |-> !dout_i);

  a_r9_lost_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_lost_i && !cs_on_i && !cs_off_i) |=> sync_lost_i);
endmodule

bind serial_readout_ctrl srd_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_act_i    (cs_act),
  .cs_on_i     (cs_on),
  .cs_off_i    (cs_off),
  .dout_i      (dout_o),
  .dout_oe_i   (dout_oe_o),
  .sample_en_i (sample_en_o),
  .conv_start_i(conv_start_o),
  .sync_lost_i (sync_lost_o)
);

// File: tb/serial_readout_ctrl_test.sv
`timescale 1ns/1ps
module serial_readout_ctrl_test;
  localparam int unsigned QUAL = 6;
  localparam int unsigned STO  = 40;
  localparam int unsigned H    = 4;
  localparam int unsigned VEC_N = 6;
  localparam logic [9:0]  VEC_W [VEC_N] = '{10'h2AA, 10'h155, 10'h3FF, 10'h000, 10'h201, 10'h1C3};
  localparam int unsigned VEC_C [VEC_N] = '{10, 16, 10, 16, 11, 13};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       ioclk = 1'b0;
  logic [9:0] result = '0;
  logic       done = 1'b0;
  logic       dout, oe, sample, start, lost;

  int checks = 0;
  int errs   = 0;
  int starts = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_readout_ctrl #(.DATA_W(10), .QUAL_CYC(QUAL), .SYNC_TO_CYC(STO),
                        .SAMPLE_EDGE(3), .CONV_EDGE(10), .LAST_EDGE(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ioclk_i(ioclk),
    .result_i(result), .conv_done_i(done),
    .dout_o(dout), .dout_oe_o(oe), .sample_en_o(sample),
    .conv_start_o(start), .sync_lost_o(lost)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (start) starts++;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cs_set(logic v);
    cs_n = v;
    repeat (QUAL + 4) tick();
  endtask

  task automatic io_clk();
    ioclk = 1'b1;
    repeat (H) tick();
    ioclk = 1'b0;
    repeat (H) tick();
  endtask

  task automatic conv_done_pulse();
    done = 1'b1;
    tick();
    done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // reset state
    chk("R1 reset oe", oe, 0);
    chk("R1 reset sample", sample, 0);
    chk("R6 reset start", start, 0);
    chk("R9 reset lost", lost, 0);

    // table walk, select toggled between frames
    for (int v = 0; v < VEC_N; v++) begin
      result = VEC_W[v];
      s0 = starts;
      cs_set(1'b0);
      chk("R2 oe on", oe, 1);
      chk("R3 msb", dout, VEC_W[v][9]);
      for (int k = 1; k <= int'(VEC_C[v]); k++) begin
        io_clk();
        if (k < 10) chk("R3 bit", dout, VEC_W[v][9-k]);
        else        chk("R4 pad low", dout, 0);
        chk("R5 window", sample, (k >= 3 && k < 10) ? 1 : 0);
      end
      chk("R6 one start", starts - s0, 1);
      chk("R9 no loss", lost, 0);
      cs_set(1'b1);
      chk("R1 oe off", oe, 0);
      conv_done_pulse();
    end

    // R2 exact qualification delay
    cs_n = 1'b0;
    repeat (QUAL + 2) tick();
    chk("R2 oe not yet", oe, 0);
    tick();
    chk("R2 oe at qual+3", oe, 1);
    cs_set(1'b1);
    // R2 short glitch ignored
    cs_n = 1'b0;
    repeat (QUAL - 2) tick();
    cs_n = 1'b1;
    repeat (QUAL + 6) tick();
    chk("R2 glitch ignored", oe, 0);

    // R1 clocks while deselected
    s0 = starts;
    for (int k = 0; k < 12; k++) io_clk();
    chk("R1 no start", starts - s0, 0);
    chk("R1 no window", sample, 0);
    chk("R1 still off", oe, 0);

    // R10 abort
    result = 10'h2D6;
    s0 = starts;
    cs_set(1'b0);
    for (int k = 0; k < 5; k++) io_clk();
    chk("R10 mid bit", dout, result[4]);
    chk("R5 window open", sample, 1);
    cs_set(1'b1);
    chk("R10 window closed", sample, 0);
    cs_set(1'b0);
    chk("R10 restart msb", dout, result[9]);
    io_clk();
    chk("R10 next bit", dout, result[8]);
    chk("R10 no start", starts - s0, 0);
    cs_set(1'b1);

    // R7 continuous select, 10-clock frames
    result = 10'h0F3;
    cs_set(1'b0);
    for (int k = 0; k < 10; k++) io_clk();
    result = 10'h30C;
    repeat (20) tick();
    chk("R7 low while busy", dout, 0);
    conv_done_pulse();
    repeat (3) tick();
    chk("R7 reload msb", dout, 1);
    chk("R7 oe kept", oe, 1);
    io_clk();
    chk("R7 count restarted", dout, 1);
    io_clk();
    chk("R7 bit7", dout, 0);
    cs_set(1'b1);
    conv_done_pulse();

    // R8 slow 16-clock continuous
    result = 10'h1FF;
    cs_set(1'b0);
    for (int k = 0; k < 11; k++) io_clk();
    result = 10'h2A5;
    conv_done_pulse();
    repeat (3) tick();
    chk("R8 no early reload", dout, 0);
    for (int k = 12; k <= 15; k++) io_clk();
    chk("R8 low before 16", dout, 0);
    io_clk();
    chk("R8 msb on 16", dout, 1);
    io_clk();
    chk("R8 next bit", dout, 0);
    chk("R9 slow no loss", lost, 0);
    cs_set(1'b1);
    conv_done_pulse();

    // R8 fast 16-clock continuous: all clocks before done
    result = 10'h155;
    cs_set(1'b0);
    for (int k = 0; k < 16; k++) io_clk();
    result = 10'h3C0;
    repeat (4) tick();
    chk("R8 wait for done", dout, 0);
    conv_done_pulse();
    repeat (3) tick();
    chk("R8 msb after done", dout, 1);
    cs_set(1'b1);
    conv_done_pulse();

    // R9 loss of sync
    result = 10'h3FF;
    cs_set(1'b0);
    for (int k = 0; k < 10; k++) io_clk();
    repeat (2 * STO) tick();
    ioclk = 1'b1;
    repeat (H) tick();
    chk("R9 lost set", lost, 1);
    chk("R9 dout low", dout, 0);
    ioclk = 1'b0;
    repeat (H) tick();
    conv_done_pulse();
    repeat (3) tick();
    chk("R9 no reload", dout, 0);
    chk("R9 still lost", lost, 1);
    cs_set(1'b1);
    chk("R9 cleared", lost, 0);
    cs_set(1'b0);
    chk("R9 recovered msb", dout, result[9]);
    cs_set(1'b1);

    summary();
  end
endmodule